// File: doc/BRIEF.md
# Addressed Multidrop Serial Node

This block is a half-duplex node for a shared differential serial bus. Each character on the line carries a ninth "mark" bit that separates address characters from payload characters. The receiver stays asleep until a marked character arrives. It then compares the five address bits of that character with its own address and with the broadcast code. On a hit it gathers a fixed number of characters and hands the whole packet to the host in a single cycle. On a miss it keeps sleeping, and unmarked traffic meant for other nodes never reaches the host.

The transmitter accepts a whole packet in one request. It turns on the line driver one bit time ahead of the first character. It sends the first character marked and the rest unmarked, and it releases the driver only when the stop bit of the last character has been on the line for its full bit time.

Bit timing comes from a plain clock divider. The receiver samples at sixteen times the bit rate. The transmitter shifts on a bit-rate divider that restarts with each request, so all of its timing is exact to the clock.

Top module: `mdrop_node`

## Requirements
- R1: A transmitted character on `txd` is a low start bit, then 7 data bits with the least significant bit first, then the mark bit, then a high stop bit. Each bit lasts 16*OVS_DIV clock cycles.
- R2: Transmit byte i of a packet is taken from `tx_data[8*i+6 : 8*i]`, and bit 7 of every byte is ignored. Byte 0 is sent with mark = 1 and every later byte with mark = 0.
- R3: `txd_en` rises in the cycle after the request is accepted. The first start bit begins one bit time later. `txd_en` falls exactly at the end of the last stop bit, so it is high for (1 + 10*L) bit times for a packet of L bytes. `txd` is high whenever `txd_en` is low.
- R4: `tx_ready` is high only while the transmitter is idle. A request is accepted when `tx_req` and `tx_ready` are both high on a clock edge. A request made while busy has no effect on the line.
- R5: A received marked character whose bits [6:2] equal `cfg_addr`, or equal 5'h1F (broadcast), opens a packet. That character becomes byte 0.
- R6: After a marked character with any other address, the receiver ignores all unmarked characters until the next marked character, and it delivers nothing.
- R7: When L = `cfg_len` bytes (2..8) have been collected, counting the address byte, `rx_valid` is high for one cycle. Byte i is at `rx_data[8*i+7 : 8*i]` in arrival order. Byte 0 has bit 7 set, every other byte has bit 7 clear, bytes at index L or above read zero, and `rx_data` changes only together with `rx_valid`.
- R8: After a delivery the receiver sleeps again, so unmarked characters that follow are not delivered.
- R9: A character whose stop bit is sampled low is a framing error. It discards the partial packet, and the receiver sleeps until the next marked character.
- R10: A matching marked character that arrives in the middle of a packet discards the bytes gathered so far and starts a new packet.
- R11: After reset, `txd` = 1, `txd_en` = 0, `tx_ready` = 1 and `rx_valid` = 0.
- R12: Reception and transmission run independently, so a packet can be received correctly while the node is transmitting.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_addr | input | 5 | Own node address |
| cfg_len | input | $clog2(MAX_LEN+1) | Packet length in bytes, including the address byte |
| rxd | input | 1 | Serial receive line |
| rx_valid | output | 1 | One-cycle pulse: a received packet is on rx_data |
| rx_data | output | 8*MAX_LEN | Received packet, byte i at bits 8*i+7..8*i |
| tx_req | input | 1 | Request to send the packet on tx_data |
| tx_data | input | 8*MAX_LEN | Packet to send, byte i at bits 8*i+7..8*i |
| tx_ready | output | 1 | Transmitter idle and able to accept a request |
| txd | output | 1 | Serial transmit line |
| txd_en | output | 1 | Line driver enable |

## Verification
A packet can arrive at `rxd` while the transmitter is still shifting out a packet of its own. The bench therefore starts a serial packet into the receiver and a transmit request in parallel. It then judges the delivered packet and the decoded `txd` characters against two separate scoreboards, and it checks the driver-enable window for that burst as well. A second overlap is a fresh `tx_req` that lands in the middle of a transmission. The bench checks that `tx_ready` is low at that point, and any extra character or second enable window the request might cause shows up as an unexpected scoreboard item.

// File: rtl/mdrop_pkg.sv
package mdrop_pkg;

    localparam int CHAR_W     = 7;
    localparam int ADDR_W     = 5;
    localparam int FRAME_BITS = 10;
    localparam int OVS        = 16;
    localparam logic [ADDR_W-1:0] BCAST_ADDR = 5'h1F;

    typedef struct packed {
        logic              mark;
        logic [CHAR_W-1:0] data;
    } sbyte_t;

    typedef enum logic [1:0] {RX_IDLE, RX_START, RX_BITS} rx_state_t;
    typedef enum logic [1:0] {TX_IDLE, TX_LEAD, TX_FRAME} tx_state_t;

    // Serial image of one character; bit 0 goes on the line first.
    function automatic logic [FRAME_BITS-1:0] frame_of(sbyte_t b);
        return {1'b1, b.mark, b.data, 1'b0};
    endfunction

    function automatic logic addr_hit(logic [ADDR_W-1:0] a, logic [ADDR_W-1:0] own);
        return (a == own) || (a == BCAST_ADDR);
    endfunction

endpackage

// File: rtl/mdrop_div.sv
module mdrop_div #(
    parameter int N = 4
) (
    input  logic clk,
    input  logic rst,
    input  logic clr,
    output logic tick
);
    localparam int W = (N > 1) ? $clog2(N) : 1;
    localparam logic [W-1:0] LAST = W'(N - 1);

    logic [W-1:0] cnt_q;

    always_ff @(posedge clk) begin
        if (rst || clr)        cnt_q <= '0;
        else if (cnt_q == LAST) cnt_q <= '0;
        else                   cnt_q <= cnt_q + 1'b1;
    end

    assign tick = (cnt_q == LAST) && !clr;
endmodule

// File: rtl/mdrop_rx.sv
module mdrop_rx
    import mdrop_pkg::*;
#(
    parameter int MAX_LEN = 8,
    localparam int LEN_W = $clog2(MAX_LEN + 1),
    localparam int IDX_W = $clog2(MAX_LEN)
) (
    input  logic                  clk,
    input  logic                  rst,
    input  logic                  ovs_tick,
    input  logic                  rxd,
    input  logic [ADDR_W-1:0]     cfg_addr,
    input  logic [LEN_W-1:0]      cfg_len,
    output logic                  rx_valid,
    output logic [MAX_LEN*8-1:0]  rx_data
);
    // ---- line synchroniser and character engine ----
    logic      s1_q, s2_q;
    rx_state_t st_q;
    logic [3:0] ph_q, bitn_q;
    logic [7:0] sh_q;
    logic       got_q, gerr_q;
    sbyte_t     gb_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            s1_q <= 1'b1;
            s2_q <= 1'b1;
        end else begin
            s1_q <= rxd;
            s2_q <= s1_q;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q   <= RX_IDLE;
            ph_q   <= '0;
            bitn_q <= '0;
            sh_q   <= '0;
            got_q  <= 1'b0;
            gerr_q <= 1'b0;
            gb_q   <= '0;
        end else begin
            got_q <= 1'b0;
            if (ovs_tick) begin
                case (st_q)
                    RX_IDLE: if (!s2_q) begin
                        st_q <= RX_START;
                        ph_q <= '0;
                    end
                    RX_START: if (ph_q == 4'd7) begin
                        ph_q   <= '0;
                        bitn_q <= '0;
                        st_q   <= s2_q ? RX_IDLE : RX_BITS;
                    end else begin
                        ph_q <= ph_q + 1'b1;
                    end
                    RX_BITS: if (ph_q == 4'(OVS - 1)) begin
                        ph_q <= '0;
                        if (bitn_q < 4'd8) begin
                            sh_q   <= {s2_q, sh_q[7:1]};
                            bitn_q <= bitn_q + 1'b1;
                        end else begin
                            got_q  <= 1'b1;
                            gerr_q <= !s2_q;
                            gb_q   <= sbyte_t'(sh_q);
                            st_q   <= RX_IDLE;
                        end
                    end else begin
                        ph_q <= ph_q + 1'b1;
                    end
                    default: st_q <= RX_IDLE;
                endcase
            end
        end
    end

    // ---- packet assembly ----
    logic                       awake_q;
    logic [LEN_W-1:0]           cnt_q;
    logic [MAX_LEN-1:0][7:0]    hold_q;
    logic [MAX_LEN-1:0][7:0]    pkt_q;
    logic                       vld_q;
    logic [IDX_W-1:0]           idx;
    logic [LEN_W-1:0]           cnt_inc;
    logic                       last_byte;

    assign idx       = cnt_q[IDX_W-1:0];
    assign cnt_inc   = cnt_q + LEN_W'(1);
    assign last_byte = (cnt_inc >= cfg_len) || (cnt_inc == LEN_W'(MAX_LEN));

    always_ff @(posedge clk) begin
        if (rst) begin
            awake_q <= 1'b0;
            cnt_q   <= '0;
            hold_q  <= '0;
            pkt_q   <= '0;
            vld_q   <= 1'b0;
        end else begin
            vld_q <= 1'b0;
            if (got_q) begin
                if (gerr_q) begin
                    awake_q <= 1'b0;
                    cnt_q   <= '0;
                end else if (gb_q.mark) begin
                    if (addr_hit(gb_q.data[6:2], cfg_addr)) begin
                        hold_q    <= '0;
                        hold_q[0] <= {1'b1, gb_q.data};
                        cnt_q     <= LEN_W'(1);
                        awake_q   <= 1'b1;
                    end else begin
                        awake_q <= 1'b0;
                        cnt_q   <= '0;
                    end
                end else if (awake_q) begin
                    if (last_byte) begin
                        for (int i = 0; i < MAX_LEN; i++)
                            pkt_q[i] <= (i == int'(idx)) ? {1'b0, gb_q.data} : hold_q[i];
                        vld_q   <= 1'b1;
                        awake_q <= 1'b0;
                        cnt_q   <= '0;
                    end else begin
                        hold_q[idx] <= {1'b0, gb_q.data};
                        cnt_q       <= cnt_inc;
                    end
                end
            end
        end
    end

    assign rx_valid = vld_q;
    assign rx_data  = pkt_q;
endmodule

// File: rtl/mdrop_tx.sv
module mdrop_tx
    import mdrop_pkg::*;
#(
    parameter int MAX_LEN = 8,
    localparam int LEN_W = $clog2(MAX_LEN + 1),
    localparam int IDX_W = $clog2(MAX_LEN)
) (
    input  logic                  clk,
    input  logic                  rst,
    input  logic                  bit_tick,
    input  logic                  tx_req,
    input  logic [MAX_LEN*8-1:0]  tx_data,
    input  logic [LEN_W-1:0]      cfg_len,
    output logic                  start,
    output logic                  tx_ready,
    output logic                  txd,
    output logic                  txd_en
);
    tx_state_t                     st_q;
    logic [MAX_LEN-1:0][CHAR_W-1:0] pay_q;
    logic [LEN_W-1:0]              len_q, idx_q, nidx;
    logic [FRAME_BITS-1:0]         sh_q, f_first, f_next;
    logic [3:0]                    bitn_q;
    logic                          txd_q, en_q;
    logic                          more;

    assign start   = (st_q == TX_IDLE) && tx_req;
    assign nidx    = idx_q + LEN_W'(1);
    assign more    = (nidx < len_q) && (nidx < LEN_W'(MAX_LEN));
    assign f_first = frame_of('{mark: 1'b1, data: pay_q[0]});
    assign f_next  = frame_of('{mark: 1'b0, data: pay_q[nidx[IDX_W-1:0]]});

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q   <= TX_IDLE;
            pay_q  <= '0;
            len_q  <= '0;
            idx_q  <= '0;
            sh_q   <= '0;
            bitn_q <= '0;
            txd_q  <= 1'b1;
            en_q   <= 1'b0;
        end else begin
            case (st_q)
                TX_IDLE: if (tx_req) begin
                    for (int i = 0; i < MAX_LEN; i++)
                        pay_q[i] <= tx_data[i*8 +: CHAR_W];
                    len_q <= cfg_len;
                    idx_q <= '0;
                    en_q  <= 1'b1;
                    st_q  <= TX_LEAD;
                end
                TX_LEAD: if (bit_tick) begin
                    txd_q  <= f_first[0];
                    sh_q   <= f_first >> 1;
                    bitn_q <= 4'd1;
                    st_q   <= TX_FRAME;
                end
                TX_FRAME: if (bit_tick) begin
                    if (bitn_q != 4'(FRAME_BITS)) begin
                        txd_q  <= sh_q[0];
                        sh_q   <= sh_q >> 1;
                        bitn_q <= bitn_q + 1'b1;
                    end else if (more) begin
                        idx_q  <= nidx;
                        txd_q  <= f_next[0];
                        sh_q   <= f_next >> 1;
                        bitn_q <= 4'd1;
                    end else begin
                        txd_q <= 1'b1;
                        en_q  <= 1'b0;
                        st_q  <= TX_IDLE;
                    end
                end
                default: st_q <= TX_IDLE;
            endcase
        end
    end

    assign tx_ready = (st_q == TX_IDLE);
    assign txd      = txd_q;
    assign txd_en   = en_q;
endmodule

// File: rtl/mdrop_node.sv
module mdrop_node
    import mdrop_pkg::*;
#(
    parameter int OVS_DIV = 81,
    parameter int MAX_LEN = 8,
    localparam int LEN_W = $clog2(MAX_LEN + 1)
) (
    input  logic                  clk,
    input  logic                  rst,
    input  logic [ADDR_W-1:0]     cfg_addr,
    input  logic [LEN_W-1:0]      cfg_len,
    input  logic                  rxd,
    output logic                  rx_valid,
    output logic [MAX_LEN*8-1:0]  rx_data,
    input  logic                  tx_req,
    input  logic [MAX_LEN*8-1:0]  tx_data,
    output logic                  tx_ready,
    output logic                  txd,
    output logic                  txd_en
);
    logic ovs_tick, bit_tick, tx_start;

    mdrop_div #(.N(OVS_DIV)) u_rxdiv (
        .clk(clk), .rst(rst), .clr(1'b0), .tick(ovs_tick)
    );

    mdrop_div #(.N(OVS * OVS_DIV)) u_txdiv (
        .clk(clk), .rst(rst), .clr(tx_start), .tick(bit_tick)
    );

    mdrop_rx #(.MAX_LEN(MAX_LEN)) u_rx (
        .clk(clk), .rst(rst), .ovs_tick(ovs_tick), .rxd(rxd),
        .cfg_addr(cfg_addr), .cfg_len(cfg_len),
        .rx_valid(rx_valid), .rx_data(rx_data)
    );

    mdrop_tx #(.MAX_LEN(MAX_LEN)) u_tx (
        .clk(clk), .rst(rst), .bit_tick(bit_tick), .tx_req(tx_req),
        .tx_data(tx_data), .cfg_len(cfg_len), .start(tx_start),
        .tx_ready(tx_ready), .txd(txd), .txd_en(txd_en)
    );
endmodule

// File: rtl/mdrop_chk.sv
module mdrop_chk #(
    parameter int MAX_LEN = 8
) (
    input logic                 clk,
    input logic                 rst,
    input logic                 txd,
    input logic                 txd_en,
    input logic                 tx_req,
    input logic                 tx_ready,
    input logic                 rx_valid,
    input logic [MAX_LEN*8-1:0] rx_data
);
    logic [MAX_LEN-1:0] top_bits;
    always_comb
        for (int i = 0; i < MAX_LEN; i++) top_bits[i] = rx_data[i*8 + 7];

    assert_idle_high_R3: assert property (@(posedge clk) disable iff (rst)
        !txd_en |-> txd);

    assert_start_driven_R3: assert property (@(posedge clk) disable iff (rst)
        $fell(txd) |-> txd_en);

    assert_ready_idle_R4: assert property (@(posedge clk) disable iff (rst)
        tx_ready |-> !txd_en);

    assert_accept_R4: assert property (@(posedge clk) disable iff (rst)
        (tx_req && tx_ready) |=> (txd_en && txd && !tx_ready));

    assert_pulse_R7: assert property (@(posedge clk) disable iff (rst)
        rx_valid |=> !rx_valid);

    assert_marker_R7: assert property (@(posedge clk) disable iff (rst)
        rx_valid |-> (top_bits[0] && ($countones(top_bits) == 1)));

    assert_data_hold_R7: assert property (@(posedge clk) disable iff (rst)
        !$stable(rx_data) |-> rx_valid);
endmodule

bind mdrop_node mdrop_chk #(.MAX_LEN(MAX_LEN)) u_chk (
    .clk(clk), .rst(rst), .txd(txd), .txd_en(txd_en), .tx_req(tx_req),
    .tx_ready(tx_ready), .rx_valid(rx_valid), .rx_data(rx_data)
);

// File: tb/test_mdrop_node.sv
module test_mdrop_node;
    localparam int OVS_DIV = 4;
    localparam int MAX_LEN = 8;
    localparam int BT      = 16 * OVS_DIV;
    localparam int LEN_W   = $clog2(MAX_LEN + 1);
    localparam logic [4:0] OWN = 5'h0A;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic [4:0] cfg_addr = OWN;
    logic [LEN_W-1:0] cfg_len = LEN_W'(4);
    logic rxd = 1'b1;
    logic rx_valid;
    logic [MAX_LEN*8-1:0] rx_data;
    logic tx_req = 1'b0;
    logic [MAX_LEN*8-1:0] tx_data = '0;
    logic tx_ready, txd, txd_en;

    always #10 clk = ~clk;

    mdrop_node #(.OVS_DIV(OVS_DIV), .MAX_LEN(MAX_LEN)) i_mdrop_node (
        .clk(clk), .rst(rst), .cfg_addr(cfg_addr), .cfg_len(cfg_len),
        .rxd(rxd), .rx_valid(rx_valid), .rx_data(rx_data),
        .tx_req(tx_req), .tx_data(tx_data), .tx_ready(tx_ready),
        .txd(txd), .txd_en(txd_en)
    );

    // per-process counters, summed at the end
    int m_chk = 0, m_err = 0;
    int r_chk = 0, r_err = 0;
    int t_chk = 0, t_err = 0;
    int e_chk = 0, e_err = 0;

    logic [63:0] rx_exp[$];
    string       rx_tag[$];
    logic [7:0]  tx_exp[$];
    int          en_exp[$];

    task automatic check(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
        m_chk++;
        if (!ok) begin
            m_err++;
            $display("FAIL %s act=%h exp=%h", tag, act, exp);
        end
    endtask

    // ---- receive side stimulus ----
    task automatic send_char(input logic mark, input logic [6:0] d, input logic stop_bit);
        logic [9:0] f;
        f = {stop_bit, mark, d, 1'b0};
        for (int b = 0; b < 10; b++) begin
            rxd = f[b];
            repeat (BT) @(negedge clk);
        end
        rxd = 1'b1;
    endtask

    function automatic logic [63:0] build_exp(input logic [4:0] a, input logic [1:0] p,
                                              input int n, input logic [55:0] bodies);
        logic [63:0] r;
        r = '0;
        r[7:0] = {1'b1, a, p};
        for (int i = 1; i < n; i++) r[i*8 +: 8] = {1'b0, bodies[(i-1)*7 +: 7]};
        return r;
    endfunction

    task automatic send_pkt(input logic [4:0] a, input logic [1:0] p, input int n, input logic [55:0] bodies);
        send_char(1'b1, {a, p}, 1'b1);
        for (int i = 1; i < n; i++) send_char(1'b0, bodies[(i-1)*7 +: 7], 1'b1);
        repeat (2 * BT) @(negedge clk);
    endtask

    task automatic expect_pkt(input logic [4:0] a, input logic [1:0] p, input int n,
                              input logic [55:0] bodies, input string tag);
        rx_exp.push_back(build_exp(a, p, n, bodies));
        rx_tag.push_back(tag);
    endtask

    // ---- transmit side stimulus ----
    task automatic tx_send(input int n, input logic [63:0] d);
        for (int i = 0; i < n; i++) tx_exp.push_back({(i == 0), d[i*8 +: 7]});
        en_exp.push_back(BT * (1 + 10 * n));
        @(negedge clk);
        tx_data = d;
        tx_req  = 1'b1;
        @(negedge clk);
        tx_req  = 1'b0;
        check(tx_ready == 1'b0, "R4 busy after accept", 64'(tx_ready), 64'd0);
    endtask

    task automatic wait_tx_idle;
        while (!tx_ready) @(negedge clk);
        repeat (2 * BT) @(negedge clk);
    endtask

    // ---- monitors (scoreboard side) ----
    always @(negedge clk) begin
        if (!rst && rx_valid) begin
            r_chk++;
            if (rx_exp.size() == 0) begin
                r_err++;
                $display("FAIL R6,R8 unexpected packet act=%h exp=none", rx_data);
            end else begin
                logic [63:0] e;
                string t;
                e = rx_exp.pop_front();
                t = rx_tag.pop_front();
                if (rx_data !== e) begin
                    r_err++;
                    $display("FAIL %s packet act=%h exp=%h", t, rx_data, e);
                end
            end
        end
    end

    initial begin : tx_mon
        logic [8:0] bits;
        forever begin
            @(negedge clk);
            if (!rst && txd === 1'b0) begin
                repeat (BT / 2) @(negedge clk);
                if (txd === 1'b0) begin
                    for (int b = 0; b < 9; b++) begin
                        repeat (BT) @(negedge clk);
                        bits[b] = txd;
                        if (txd_en !== 1'b1) begin
                            t_chk++; t_err++;
                            $display("FAIL R3 driver off mid-character act=%b exp=1", txd_en);
                        end
                    end
                    t_chk++;
                    if (bits[8] !== 1'b1) begin
                        t_err++;
                        $display("FAIL R1 stop bit act=%b exp=1", bits[8]);
                    end
                    t_chk++;
                    if (tx_exp.size() == 0) begin
                        t_err++;
                        $display("FAIL R4 unexpected character act=%h exp=none", bits[7:0]);
                    end else begin
                        logic [7:0] e;
                        e = tx_exp.pop_front();
                        if (bits[7:0] !== e) begin
                            t_err++;
                            $display("FAIL R1,R2 character act=%h exp=%h", bits[7:0], e);
                        end
                    end
                end
            end
        end
    end

    initial begin : en_mon
        int width;
        forever begin
            @(negedge clk);
            if (!rst && txd_en === 1'b1) begin
                width = 0;
                while (txd_en === 1'b1) begin
                    width++;
                    @(negedge clk);
                end
                e_chk++;
                if (en_exp.size() == 0) begin
                    e_err++;
                    $display("FAIL R4 unexpected enable window act=%0d exp=none", width);
                end else begin
                    int e;
                    e = en_exp.pop_front();
                    if (width != e) begin
                        e_err++;
                        $display("FAIL R3 enable window act=%0d exp=%0d", width, e);
                    end
                end
            end
        end
    end

    task automatic summary(input int extra_err, input int extra_chk);
        $display("Result: errors=%0d of %0d checks",
                 m_err + r_err + t_err + e_err + extra_err,
                 m_chk + r_chk + t_chk + e_chk + extra_chk);
    endtask

    initial begin : watchdog
        repeat (150000) @(posedge clk);
        $display("FAIL watchdog expired act=running exp=done");
        summary(1, 1);
        $finish;
    end

    // ---- main sequence ----
    initial begin : main
        repeat (5) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        check(txd == 1'b1,      "R11 txd",      64'(txd), 64'd1);
        check(txd_en == 1'b0,   "R11 txd_en",   64'(txd_en), 64'd0);
        check(tx_ready == 1'b1, "R11 tx_ready", 64'(tx_ready), 64'd1);
        check(rx_valid == 1'b0, "R11 rx_valid", 64'(rx_valid), 64'd0);
        repeat (2 * BT) @(negedge clk);

        // R5 R7: own address, length 4
        expect_pkt(OWN, 2'b01, 4, {35'd0, 7'h7F, 7'h6A, 7'h15}, "R5,R7 own");
        send_pkt(OWN, 2'b01, 4, {35'd0, 7'h7F, 7'h6A, 7'h15});
        // R5: broadcast
        expect_pkt(5'h1F, 2'b10, 4, {35'd0, 7'h2A, 7'h55, 7'h00}, "R5 broadcast");
        send_pkt(5'h1F, 2'b10, 4, {35'd0, 7'h2A, 7'h55, 7'h00});
        // R6: foreign address ignored, then own
        send_pkt(5'h03, 2'b00, 4, {35'd0, 7'h33, 7'h22, 7'h11});
        expect_pkt(OWN, 2'b00, 4, {35'd0, 7'h33, 7'h22, 7'h11}, "R6 after foreign");
        send_pkt(OWN, 2'b00, 4, {35'd0, 7'h33, 7'h22, 7'h11});
        // R8: trailing unmarked characters after delivery are dropped
        expect_pkt(OWN, 2'b11, 4, {35'd0, 7'h03, 7'h02, 7'h01}, "R8 first");
        send_pkt(OWN, 2'b11, 4, {35'd0, 7'h03, 7'h02, 7'h01});
        send_char(1'b0, 7'h44, 1'b1);
        send_char(1'b0, 7'h45, 1'b1);
        repeat (2 * BT) @(negedge clk);
        expect_pkt(OWN, 2'b10, 4, {35'd0, 7'h0C, 7'h0B, 7'h0A}, "R8 second");
        send_pkt(OWN, 2'b10, 4, {35'd0, 7'h0C, 7'h0B, 7'h0A});
        // R9: framing error discards the partial packet
        send_char(1'b1, {OWN, 2'b00}, 1'b1);
        send_char(1'b0, 7'h01, 1'b1);
        send_char(1'b0, 7'h02, 1'b0);
        repeat (BT) @(negedge clk);
        send_char(1'b0, 7'h03, 1'b1);
        send_char(1'b0, 7'h04, 1'b1);
        repeat (2 * BT) @(negedge clk);
        expect_pkt(OWN, 2'b01, 4, {35'd0, 7'h5A, 7'h4B, 7'h3C}, "R9 recovery");
        send_pkt(OWN, 2'b01, 4, {35'd0, 7'h5A, 7'h4B, 7'h3C});
        // R10: new matching address mid-packet restarts
        send_char(1'b1, {OWN, 2'b11}, 1'b1);
        send_char(1'b0, 7'h09, 1'b1);
        expect_pkt(OWN, 2'b01, 4, {35'd0, 7'h0D, 7'h0C, 7'h0B}, "R10 restart");
        send_pkt(OWN, 2'b01, 4, {35'd0, 7'h0D, 7'h0C, 7'h0B});
        // R7: maximum length 8
        cfg_len = LEN_W'(8);
        expect_pkt(OWN, 2'b10, 8, {7'h77, 7'h66, 7'h55, 7'h44, 7'h33, 7'h22, 7'h11, 7'h70}, "R7 length 8");
        send_pkt(OWN, 2'b10, 8, {7'h77, 7'h66, 7'h55, 7'h44, 7'h33, 7'h22, 7'h11, 7'h70});
        // R1 R2 R3: length-8 transmit
        tx_send(8, 64'h88_17_26_35_44_D3_E2_F1);
        wait_tx_idle();
        // R7: minimum length 2, upper bytes zero
        cfg_len = LEN_W'(2);
        expect_pkt(5'h1F, 2'b01, 2, {49'd0, 7'h5D}, "R7 length 2 zero fill");
        send_pkt(5'h1F, 2'b01, 2, {49'd0, 7'h5D});
        cfg_len = LEN_W'(4);

        // R2 masking, R4 refusal while busy
        tx_send(4, 64'h0000_0000_F1_80_C5_A3);
        repeat (300) @(negedge clk);
        check(tx_ready == 1'b0, "R4 ready low mid-packet", 64'(tx_ready), 64'd0);
        tx_data = 64'h7F7F_7F7F_7F7F_7F7F;
        tx_req  = 1'b1;
        @(negedge clk);
        tx_req  = 1'b0;
        wait_tx_idle();

        // R12: receive and transmit at once
        expect_pkt(5'h1F, 2'b11, 4, {35'd0, 7'h61, 7'h52, 7'h43}, "R12 concurrent rx");
        fork
            send_pkt(5'h1F, 2'b11, 4, {35'd0, 7'h61, 7'h52, 7'h43});
            tx_send(4, 64'h0000_0000_12_34_56_78);
        join
        wait_tx_idle();
        repeat (4 * BT) @(negedge clk);

        check(rx_exp.size() == 0, "R7 all packets delivered", 64'(rx_exp.size()), 64'd0);
        check(tx_exp.size() == 0, "R1 all characters sent", 64'(tx_exp.size()), 64'd0);
        check(en_exp.size() == 0, "R3 all enable windows", 64'(en_exp.size()), 64'd0);
        check(txd == 1'b1 && txd_en == 1'b0, "R3 line idle at end", {62'd0, txd, txd_en}, 64'd2);
        summary(0, 0);
        $finish;
    end
endmodule